// File: doc/BRIEF.md
# Clock-Domain Register Bridge with Shared Handshake

This block sits between an APB slave port, clocked by the bus clock, and a small file of core registers clocked by a separate functional clock. Bus-side registers answer at once. Every write to a core register crosses into the core clock through one toggle-based request/acknowledge handshake. Reads of core registers marked as needing synchronization also use that handshake. The handshake runs at any clock ratio, including equal clocks from one source.

Only one crossing can be in flight. A status register reports this with a busy bit. A synchronized write is posted: it completes at once when the crossing is free. A later synchronized access is held with wait states until the crossing is free again. A synchronized read stalls until the core domain has captured the value and the acknowledge has returned.

Logic in the core clock domain can also update any core register through a hardware update port. Core registers that are not synchronized on read return a bus-side copy of the last value written from the bus, so hardware updates to them are not visible on a bus read. Read-synchronized registers return the live core value.

Top module: `reg_xdom_sync`

## Requirements
- R1: After reset, every readable location reads 0, the busy bit is 0 and all core register outputs are 0.
- R2: Bus registers at word index 1..NUM_BUS (byte address = index*4) are written and read with no wait state (pready high in the first access cycle).
- R3: A write to a core register (word index NUM_BUS+1+k for core register k) completes with no wait state when the crossing is idle. Register k on `core_regs` (bits k*DW and up) takes the written value once busy has cleared.
- R4: Word index 0 is a status register: bit 0 is the busy bit, all other bits read 0, and writes to it are ignored. Busy reads 1 directly after a core write has been accepted.
- R5: While busy is 1, any further synchronized access is held with pready low until the crossing is free. Bus-register, status, unmapped and non-synchronized reads still complete with no wait state.
- R6: A core register k whose bit k in RD_SYNC is 1 returns its current core-domain value, including hardware updates, after at least one wait state.
- R7: A core register whose RD_SYNC bit is 0 returns, with no wait state, the last value written to it from the bus, even after a hardware update changed the core copy.
- R8: Synchronization always takes effect later than the bus transfer: when a posted core write completes on the bus, `core_regs` still holds the old value.
- R9: Busy clears within BUSY_MAX bus clock cycles of being set.
- R10: Word indices above NUM_BUS+NUM_CORE read 0 with no wait state, and writes to them change no register.
- R11: A core-clock cycle with `hw_we` high writes `hw_wdata` into core register `hw_idx`.
- R12: A core register changes only on an arriving synchronized write or a hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | AW | APB byte address, word index in bits AW-1:2 |
| pwdata | input | DW | APB write data |
| pready | output | 1 | APB ready, low inserts wait states |
| prdata | output | DW | APB read data |
| cclk | input | 1 | Core clock |
| crstn | input | 1 | Core-domain reset, active low |
| hw_we | input | 1 | Core-side hardware update strobe |
| hw_idx | input | CIW | Core register addressed by the update |
| hw_wdata | input | DW | Core-side update value |
| core_regs | output | NUM_CORE*DW | Core register file, register k at bits k*DW+DW-1:k*DW |

## Verification
The bench issues a core write and then a second synchronized access immediately after it. A bridge that let two crossings overlap would return pready high there, or would corrupt the held index and data. It checks that bus-register and non-synchronized reads still complete with no wait state while busy is set. A design that stalled every access on busy fails there. The bench reads read-synchronized registers after core-side hardware updates and compares the result against non-synchronized registers that must keep the bus copy. A design with the attribute decode swapped or ignored returns the wrong one of the two values. It also samples `core_regs` at the moment a posted write completes: a bridge that bypassed the crossing would already show the new value. Random mixed traffic, with polling of the busy bit, catches lost or duplicated toggles as a mismatch or a busy bit that never clears.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef enum logic [1:0] {
    SY_IDLE,
    SY_WR,
    SY_RD
  } sy_state_e;

  typedef enum logic [1:0] {
    K_STAT,
    K_BUS,
    K_CORE,
    K_NONE
  } reg_kind_e;

  // Word index map: 0 status, 1..nb bus registers, nb+1..nb+nc core registers.
  function automatic reg_kind_e kind_of(input int unsigned idx,
                                        input int unsigned nb,
                                        input int unsigned nc);
    if (idx == 0) return K_STAT;
    if (idx <= nb) return K_BUS;
    if (idx <= nb + nc) return K_CORE;
    return K_NONE;
  endfunction

endpackage

// File: rtl/xs_tog_sync.sv
module xs_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/xs_bus_side.sv
module xs_bus_side
  import xs_pkg::*;
#(
  parameter int NUM_BUS  = 2,
  parameter int NUM_CORE = 4,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter logic [NUM_CORE-1:0] RD_SYNC = '0,
  localparam int CIW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int BIW = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic           pready,
  output logic [DW-1:0]  prdata,
  output logic           req_tgl,
  input  logic           ack_s,
  output logic [CIW-1:0] hold_idx,
  output logic [DW-1:0]  hold_data,
  output logic           hold_dir,
  input  logic [DW-1:0]  rd_data_i,
  output logic           busy,
  output logic           launch,
  output logic           ack_edge
);
  sy_state_e       state;
  logic            ack_seen;
  logic [DW-1:0]   bus_q  [NUM_BUS];
  logic [DW-1:0]   shad_q [NUM_CORE];

  logic [AW-3:0]   idx;
  int unsigned     idx_u;
  reg_kind_e       kind;
  logic [BIW-1:0]  bsel;
  logic [CIW-1:0]  csel;
  logic            rs_attr;
  logic            access;
  logic            is_sync;
  logic            rd_done;
  logic            unused_lsb;

  assign idx        = paddr[AW-1:2];
  assign unused_lsb = ^paddr[1:0];

  always_comb begin
    idx_u   = 32'(idx);
    kind    = kind_of(idx_u, NUM_BUS, NUM_CORE);
    bsel    = BIW'(idx_u - 32'd1);
    csel    = CIW'(idx_u - 32'(NUM_BUS) - 32'd1);
    rs_attr = (kind == K_CORE) && RD_SYNC[csel];
  end

  assign access   = psel && penable;
  assign is_sync  = access && (kind == K_CORE) && (pwrite || rs_attr);
  assign busy     = (state != SY_IDLE);
  assign launch   = is_sync && !busy;
  assign ack_edge = ack_s ^ ack_seen;
  assign rd_done  = (state == SY_RD) && ack_edge;

  always_comb begin
    pready = 1'b1;
    if (is_sync) pready = (launch && pwrite) || rd_done;
  end

  always_comb begin
    unique case (kind)
      K_STAT:  prdata = DW'(busy);
      K_BUS:   prdata = bus_q[bsel];
      K_CORE:  prdata = rs_attr ? rd_data_i : shad_q[csel];
      default: prdata = '0;
    endcase
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      state     <= SY_IDLE;
      req_tgl   <= 1'b0;
      ack_seen  <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
      hold_dir  <= 1'b0;
      for (int i = 0; i < NUM_BUS; i++)  bus_q[i]  <= '0;
      for (int i = 0; i < NUM_CORE; i++) shad_q[i] <= '0;
    end else begin
      ack_seen <= ack_s;
      if (launch) begin
        req_tgl   <= ~req_tgl;
        hold_idx  <= csel;
        hold_data <= pwdata;
        hold_dir  <= pwrite;
        state     <= pwrite ? SY_WR : SY_RD;
        if (pwrite) shad_q[csel] <= pwdata;
      end else if (ack_edge) begin
        state <= SY_IDLE;
      end
      if (access && pwrite && kind == K_BUS) bus_q[bsel] <= pwdata;
    end
  end
endmodule

// File: rtl/xs_core_side.sv
module xs_core_side #(
  parameter int NUM_CORE = 4,
  parameter int DW       = 32,
  localparam int CIW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                   cclk,
  input  logic                   crstn,
  input  logic                   req_s,
  input  logic [CIW-1:0]         hold_idx,
  input  logic [DW-1:0]          hold_data,
  input  logic                   hold_dir,
  input  logic                   hw_we,
  input  logic [CIW-1:0]         hw_idx,
  input  logic [DW-1:0]          hw_wdata,
  output logic                   ack_tgl,
  output logic [DW-1:0]          rd_hold,
  output logic [NUM_CORE*DW-1:0] core_regs,
  output logic                   apply
);
  logic          req_seen;
  logic [DW-1:0] regs [NUM_CORE];

  assign apply = req_s ^ req_seen;

  always_ff @(posedge cclk or negedge crstn) begin
    if (!crstn) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      rd_hold  <= '0;
      for (int i = 0; i < NUM_CORE; i++) regs[i] <= '0;
    end else begin
      req_seen <= req_s;
      if (hw_we) regs[hw_idx] <= hw_wdata;
      if (apply) begin
        ack_tgl <= ~ack_tgl;
        if (hold_dir) regs[hold_idx] <= hold_data;
        else          rd_hold        <= regs[hold_idx];
      end
    end
  end

  for (genvar k = 0; k < NUM_CORE; k++) begin : g_flat
    assign core_regs[k*DW +: DW] = regs[k];
  end
endmodule

// File: rtl/reg_xdom_sync.sv
module reg_xdom_sync #(
  parameter int NUM_BUS  = 2,
  parameter int NUM_CORE = 4,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter logic [NUM_CORE-1:0] RD_SYNC = 4'b1010,
  parameter int BUSY_MAX = 64,
  localparam int CIW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                   pclk,
  input  logic                   presetn,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [AW-1:0]          paddr,
  input  logic [DW-1:0]          pwdata,
  output logic                   pready,
  output logic [DW-1:0]          prdata,
  input  logic                   cclk,
  input  logic                   crstn,
  input  logic                   hw_we,
  input  logic [CIW-1:0]         hw_idx,
  input  logic [DW-1:0]          hw_wdata,
  output logic [NUM_CORE*DW-1:0] core_regs
);
  logic           req_tgl, req_s;
  logic           ack_tgl, ack_s;
  logic [CIW-1:0] hold_idx;
  logic [DW-1:0]  hold_data;
  logic           hold_dir;
  logic [DW-1:0]  rd_hold;
  logic           busy, launch, ack_edge, apply;

  xs_bus_side #(
    .NUM_BUS(NUM_BUS), .NUM_CORE(NUM_CORE), .DW(DW), .AW(AW), .RD_SYNC(RD_SYNC)
  ) u_bus (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pready(pready),
    .prdata(prdata), .req_tgl(req_tgl), .ack_s(ack_s), .hold_idx(hold_idx),
    .hold_data(hold_data), .hold_dir(hold_dir), .rd_data_i(rd_hold),
    .busy(busy), .launch(launch), .ack_edge(ack_edge)
  );

  xs_tog_sync #(.STAGES(2)) u_req_sync (
    .clk(cclk), .rst_n(crstn), .d(req_tgl), .q(req_s)
  );

  xs_tog_sync #(.STAGES(2)) u_ack_sync (
    .clk(pclk), .rst_n(presetn), .d(ack_tgl), .q(ack_s)
  );

  xs_core_side #(.NUM_CORE(NUM_CORE), .DW(DW)) u_core (
    .cclk(cclk), .crstn(crstn), .req_s(req_s), .hold_idx(hold_idx),
    .hold_data(hold_data), .hold_dir(hold_dir), .hw_we(hw_we),
    .hw_idx(hw_idx), .hw_wdata(hw_wdata), .ack_tgl(ack_tgl),
    .rd_hold(rd_hold), .core_regs(core_regs), .apply(apply)
  );
endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
  parameter int NUM_BUS  = 2,
  parameter int NUM_CORE = 4,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int BUSY_MAX = 64,
  parameter int CIW      = 2
) (
  input logic                   pclk,
  input logic                   presetn,
  input logic                   cclk,
  input logic                   crstn,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [AW-1:0]          paddr,
  input logic                   pready,
  input logic [DW-1:0]          prdata,
  input logic                   busy,
  input logic                   launch,
  input logic                   ack_edge,
  input logic [CIW-1:0]         hold_idx,
  input logic [DW-1:0]          hold_data,
  input logic                   apply,
  input logic                   hw_we,
  input logic [NUM_CORE*DW-1:0] core_regs
);
  int unsigned widx;
  logic        unused_chk;
  logic [15:0] busy_cnt;

  assign widx       = 32'(paddr[AW-1:2]);
  assign unused_chk = ^paddr[1:0];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)  busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  a_r5_single_flight: assert property (@(posedge pclk) disable iff (!presetn)
    launch |-> !busy);

  a_r5_launch_sets_busy: assert property (@(posedge pclk) disable iff (!presetn)
    launch |=> busy);

  a_r3_hold_stable: assert property (@(posedge pclk) disable iff (!presetn)
    busy |=> ($stable(hold_idx) && $stable(hold_data)));

  a_r9_busy_bounded: assert property (@(posedge pclk) disable iff (!presetn)
    busy_cnt < 16'(BUSY_MAX));

  a_r9_ack_only_busy: assert property (@(posedge pclk) disable iff (!presetn)
    ack_edge |-> busy);

  a_r2_bus_zero_wait: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && widx >= 1 && widx <= 32'(NUM_BUS)) |-> pready);

  a_r10_unmapped_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && widx > 32'(NUM_BUS + NUM_CORE))
      |-> (pready && prdata == '0));

  a_r4_status_busy: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && widx == 0) |-> (pready && prdata == DW'(busy)));

  a_r12_core_quiet: assert property (@(posedge cclk) disable iff (!crstn)
    (!apply && !hw_we) |=> $stable(core_regs));
endmodule

bind reg_xdom_sync xs_chk #(
  .NUM_BUS(NUM_BUS), .NUM_CORE(NUM_CORE), .DW(DW), .AW(AW),
  .BUSY_MAX(BUSY_MAX), .CIW(CIW)
) u_chk (
  .pclk(pclk), .presetn(presetn), .cclk(cclk), .crstn(crstn),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
  .pready(pready), .prdata(prdata), .busy(busy), .launch(launch),
  .ack_edge(ack_edge), .hold_idx(hold_idx), .hold_data(hold_data),
  .apply(apply), .hw_we(hw_we), .core_regs(core_regs)
);

// File: tb/test_reg_xdom_sync.sv
module test_reg_xdom_sync;
  localparam int NB = 2;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [NC-1:0] RS = 4'b1010;
  localparam int BMAX = 64;

  logic pclk = 0, cclk = 0;
  logic presetn = 0, crstn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic pready;
  logic [DW-1:0] prdata;
  logic hw_we = 0;
  logic [1:0] hw_idx = '0;
  logic [DW-1:0] hw_wdata = '0;
  logic [NC*DW-1:0] core_regs;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] bus_m [NB];
  logic [DW-1:0] shad_m [NC];
  logic [DW-1:0] core_m [NC];

  always #5 pclk = ~pclk;
  always #7 cclk = ~cclk;

  reg_xdom_sync #(.NUM_BUS(NB), .NUM_CORE(NC), .DW(DW), .AW(AW), .RD_SYNC(RS),
                  .BUSY_MAX(BMAX)) i_reg_xdom_sync (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pready(pready),
    .prdata(prdata), .cclk(cclk), .crstn(crstn), .hw_we(hw_we),
    .hw_idx(hw_idx), .hw_wdata(hw_wdata), .core_regs(core_regs)
  );

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input int idx);
    if (idx >= 1 && idx <= NB) return bus_m[idx-1];
    if (idx > NB && idx <= NB + NC) begin
      int k = idx - NB - 1;
      return RS[k] ? core_m[k] : shad_m[k];
    end
    return '0;
  endfunction

  function automatic bit exp_stall(input int idx);
    return (idx > NB && idx <= NB + NC) && RS[idx-NB-1];
  endfunction

  function automatic logic [DW-1:0] core_of(input int k);
    return core_regs[k*DW +: DW];
  endfunction

  task automatic apb(input bit wr, input int idx, input logic [DW-1:0] wd,
                     output logic [DW-1:0] rd, output int waits);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = AW'(idx * 4); pwdata = wd;
    @(negedge pclk);
    penable = 1; waits = 0;
    #1;
    while (!pready && waits < 300) begin
      @(negedge pclk); #1; waits++;
    end
    if (!pready) check(0, "watchdog (R9)", '0, 32'd1);
    rd = prdata;
    @(posedge pclk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] st;
    int w;
    int polls = 0;
    st = 32'd1;
    while (st[0] && polls < BMAX) begin
      apb(0, 0, '0, st, w);
      polls++;
    end
    check(!st[0], "R9 busy clears", st, '0);
  endtask

  task automatic hw_write(input int k, input logic [DW-1:0] d);
    @(negedge cclk);
    hw_we = 1; hw_idx = 2'(k); hw_wdata = d;
    @(negedge cclk);
    hw_we = 0;
    core_m[k] = d;
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", '0, '1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, d;
    int w, w2;
    void'($urandom(32'd7));
    for (int i = 0; i < NB; i++) bus_m[i] = '0;
    for (int i = 0; i < NC; i++) begin shad_m[i] = '0; core_m[i] = '0; end
    repeat (4) @(posedge pclk);
    #1 presetn = 1; crstn = 1;

    // R1 reset values
    for (int i = 0; i <= NB + NC + 2; i++) begin
      apb(0, i, '0, rd, w);
      check(rd == '0, "R1 reset read", rd, '0);
    end
    check(core_regs == '0, "R1 core reset", core_regs[DW-1:0], '0);

    // R2 bus registers
    apb(1, 1, 32'hA5A5_0001, rd, w);
    check(w == 0, "R2 write no wait", w, 0);
    bus_m[0] = 32'hA5A5_0001;
    apb(1, 2, 32'h5A5A_0002, rd, w); bus_m[1] = 32'h5A5A_0002;
    apb(0, 1, '0, rd, w);
    check(rd == bus_m[0] && w == 0, "R2 read bus reg 1", rd, bus_m[0]);
    apb(0, 2, '0, rd, w);
    check(rd == bus_m[1], "R2 read bus reg 2", rd, bus_m[1]);

    // R4 status write ignored
    apb(1, 0, '1, rd, w);
    apb(0, 0, '0, rd, w);
    check(rd == '0, "R4 status write ignored", rd, '0);

    // R3 / R8 / R4 posted core write
    apb(1, 3, 32'h1111_2222, rd, w);
    shad_m[0] = 32'h1111_2222; core_m[0] = 32'h1111_2222;
    check(w == 0, "R3 posted write no wait", w, 0);
    check(core_of(0) == '0, "R8 core not yet updated", core_of(0), '0);
    apb(0, 0, '0, rd, w);
    check(rd == 32'd1, "R4 busy after write", rd, 32'd1);
    wait_idle();
    check(core_of(0) == 32'h1111_2222, "R3 core updated", core_of(0), 32'h1111_2222);

    // R5 one crossing at a time
    apb(1, 4, 32'h3333_4444, rd, w);
    shad_m[1] = 32'h3333_4444; core_m[1] = 32'h3333_4444;
    apb(1, 5, 32'h5555_6666, rd, w2);
    shad_m[2] = 32'h5555_6666; core_m[2] = 32'h5555_6666;
    check(w2 > 0, "R5 second sync write stalls", w2, 1);
    apb(0, 1, '0, rd, w);
    check(w == 0 && rd == bus_m[0], "R5 bus read while busy", rd, bus_m[0]);
    apb(0, 3, '0, rd, w);
    check(w == 0 && rd == shad_m[0], "R5 non-sync core read while busy", rd, shad_m[0]);
    wait_idle();
    check(core_of(2) == 32'h5555_6666, "R3 second core write", core_of(2), 32'h5555_6666);

    // R11 / R6 hardware update seen on read-synced register
    hw_write(1, 32'hCAFE_0001);
    check(core_of(1) == 32'hCAFE_0001, "R11 hw update", core_of(1), 32'hCAFE_0001);
    apb(0, 4, '0, rd, w);
    check(rd == 32'hCAFE_0001, "R6 live core value", rd, 32'hCAFE_0001);
    check(w > 0, "R6 read stalls", w, 1);

    // R7 non-read-synced keeps bus copy
    hw_write(0, 32'hBEEF_0000);
    apb(0, 3, '0, rd, w);
    check(rd == 32'h1111_2222 && w == 0, "R7 bus copy", rd, 32'h1111_2222);

    // R10 unmapped
    apb(1, NB + NC + 1, 32'hDEAD_DEAD, rd, w);
    apb(1, 63, 32'hDEAD_DEAD, rd, w);
    apb(0, NB + NC + 1, '0, rd, w);
    check(rd == '0 && w == 0, "R10 unmapped read", rd, '0);
    apb(0, 63, '0, rd, w);
    check(rd == '0, "R10 unmapped read high", rd, '0);
    repeat (10) @(posedge pclk);
    for (int k = 0; k < NC; k++)
      check(core_of(k) == core_m[k], "R10 R12 core untouched", core_of(k), core_m[k]);
    for (int i = 1; i <= NB; i++) begin
      apb(0, i, '0, rd, w);
      check(rd == bus_m[i-1], "R10 bus untouched", rd, bus_m[i-1]);
    end

    // random mix
    for (int n = 0; n < 200; n++) begin
      int op = $urandom_range(0, 5);
      int idx;
      d = $urandom();
      case (op)
        0: begin
          idx = $urandom_range(1, NB);
          apb(1, idx, d, rd, w); bus_m[idx-1] = d;
        end
        1: begin
          idx = $urandom_range(1, NB + NC + 3);
          apb(0, idx, '0, rd, w);
          check(rd == exp_read(idx), "R2 R6 R7 random read", rd, exp_read(idx));
          if (!exp_stall(idx))
            check(w == 0, "R7 random zero-wait read", w, 0);
        end
        2: begin
          int k = $urandom_range(0, NC - 1);
          apb(1, NB + 1 + k, d, rd, w);
          shad_m[k] = d; core_m[k] = d;
        end
        3: begin
          wait_idle();
          hw_write($urandom_range(0, NC - 1), d);
        end
        4: begin
          apb(1, $urandom_range(NB + NC + 1, 63), d, rd, w);
        end
        default: begin
          wait_idle();
          for (int k = 0; k < NC; k++)
            check(core_of(k) == core_m[k], "R3 R12 random core", core_of(k), core_m[k]);
        end
      endcase
    end
    wait_idle();
    for (int k = 0; k < NC; k++)
      check(core_of(k) == core_m[k], "R3 final core", core_of(k), core_m[k]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule